// File: doc/BRIEF.md
# Strobed Parallel Port Bridge

This block joins an external microcontroller's 8-bit shared data bus to two FIFOs inside the chip. One FIFO carries bytes inbound, and the other holds bytes waiting to go out. The microcontroller runs every transfer. A direction pin selects whether it is writing or reading. A strobe pin, which toggles only when a transfer is wanted, marks each byte. The strobe is treated as an asynchronous event and is never used as a clock. The strobe, the direction pin and the bus are passed through a two-flop synchronizer into the system clock domain. A rising edge of the synchronized strobe then becomes exactly one single-cycle push or pop.

The chip's pad ring does the tri-state buffering. This block drives the pad data and a single output enable, and it raises the enable only while the microcontroller is reading. A ready pin tells the microcontroller that outbound data is waiting. The bus register always shows the head byte of the outbound FIFO, and it moves to the next byte after each pop, so the value is settled well before the next strobe. Each strobe phase, high and low, must last at least three system clock periods.

Stream rules. On the inbound side, `ib_valid` is a one-cycle offer. The byte is accepted only if `ib_ready` is high in that same cycle. If `ib_ready` is low, the byte is dropped and `ovf_flag` is set. The valid signal is not held, because the microcontroller has already moved on. On the outbound side, `ob_ready` is a one-cycle pop. It is raised only while `ob_valid` is high, and `ob_data` must be the head entry.

Top module: `pport_bridge`

## Requirements
- R1: A rising edge of `mcu_strobe` is seen through two synchronizer flops. The resulting push or pop pulse is high for exactly the one cycle that follows the second clock edge after the rise. A falling edge produces no transfer.
- R2: With `mcu_dir` = 1 (the microcontroller writes), each strobe rise gives one `ib_valid` pulse. The pulse carries the `pad_in` value that was synchronized alongside the strobe, and no pop occurs.
- R3: With `mcu_dir` = 0 (the microcontroller reads), each strobe rise gives one `ob_ready` pulse when `ob_valid` is high, and no push occurs.
- R4: A strobe produces exactly one transfer however long its high phase lasts. The push and pop pulses never last two cycles.
- R5: `pad_oe` becomes 1 on the third clock edge after `mcu_dir` falls, and it becomes 0 on the third clock edge after `mcu_dir` rises.
- R6: `pad_out` follows the outbound head one cycle after it appears, moves to the next byte after each pop, and keeps its last value while the FIFO is empty.
- R7: `mcu_ready` equals `ob_valid` delayed by one clock.
- R8: A push offered while `ib_ready` is low is dropped and sets `ovf_flag`. The flag stays set until reset.
- R9: A read strobe while `ob_valid` is low pops nothing and sets `unf_flag`. The flag stays set until reset.
- R10: A synchronous active-high `rst` clears the synchronizers, both flags, `pad_oe`, `mcu_ready` and `pad_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mcu_strobe | input | 1 | Transfer strobe from the microcontroller (asynchronous) |
| mcu_dir | input | 1 | 1: the microcontroller writes, 0: the microcontroller reads |
| pad_in | input | DATA_W | Bus value seen at the pads |
| pad_out | output | DATA_W | Value this block drives onto the bus |
| pad_oe | output | 1 | Pad output enable; 0 leaves the bus at high impedance |
| mcu_ready | output | 1 | Outbound data waiting |
| ib_valid | output | 1 | Inbound push offer (one cycle) |
| ib_ready | input | 1 | Inbound FIFO has room |
| ib_data | output | DATA_W | Inbound byte |
| ob_valid | input | 1 | Outbound FIFO not empty |
| ob_ready | output | 1 | Outbound pop (one cycle) |
| ob_data | input | DATA_W | Outbound FIFO head |
| ovf_flag | output | 1 | Sticky inbound overflow |
| unf_flag | output | 1 | Sticky outbound underflow |

## Verification
A strobe rise driven between two clock edges shows up as a push or pop pulse after the second following edge, and that pulse is gone after the third edge. The output enable settles on the third edge after a direction change, and the ready pin trails the FIFO state by one edge. The bench drives inputs on falling edges and samples at exactly those offsets, checking both just before and at the edge where each output is due. Whole transfers leave four or more spare cycles before bus values and FIFO contents are compared, and the FIFO models apply each handshake one falling edge after they see it, which mirrors the edge at which the design commits it.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {
    XFER_READ  = 1'b0,
    XFER_WRITE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pp_edge.sv
module pp_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/pp_rx_path.sv
module pp_rx_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_rise,
  input  logic [W-1:0] bus_sample,
  output logic         ib_valid,
  input  logic         ib_ready,
  output logic [W-1:0] ib_data,
  output logic         ovf_flag
);
  logic ovf_q;

  assign ib_valid = wr_rise;
  assign ib_data  = bus_sample;

  always_ff @(posedge clk) begin
    if (rst)                      ovf_q <= 1'b0;
    else if (wr_rise && !ib_ready) ovf_q <= 1'b1;
  end

  assign ovf_flag = ovf_q;
endmodule

// File: rtl/pp_tx_path.sv
module pp_tx_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_rise,
  input  logic         rd_mode,
  input  logic         ob_valid,
  input  logic [W-1:0] ob_data,
  output logic         ob_ready,
  output logic [W-1:0] pad_out,
  output logic         pad_oe,
  output logic         mcu_ready,
  output logic         unf_flag
);
  logic [W-1:0] out_q;
  logic         oe_q, rdy_q, unf_q;

  assign ob_ready = rd_rise & ob_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= 1'b0;
      rdy_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (ob_valid) out_q <= ob_data;
      oe_q  <= rd_mode;
      rdy_q <= ob_valid;
      if (rd_rise && !ob_valid) unf_q <= 1'b1;
    end
  end

  assign pad_out   = out_q;
  assign pad_oe    = oe_q;
  assign mcu_ready = rdy_q;
  assign unf_flag  = unf_q;
endmodule

// File: rtl/pport_bridge.sv
module pport_bridge #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mcu_strobe,
  input  logic              mcu_dir,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic              pad_oe,
  output logic              mcu_ready,
  output logic              ib_valid,
  input  logic              ib_ready,
  output logic [DATA_W-1:0] ib_data,
  input  logic              ob_valid,
  output logic              ob_ready,
  input  logic [DATA_W-1:0] ob_data,
  output logic              ovf_flag,
  output logic              unf_flag
);
  import pp_pkg::*;

  localparam int SW = DATA_W + 2;

  logic [SW-1:0]     sync_q;
  logic              strobe_s, rise;
  logic [DATA_W-1:0] bus_s;
  xfer_dir_e         dir_s;

  pp_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mcu_dir, mcu_strobe, pad_in}),
    .q   (sync_q)
  );

  assign dir_s    = xfer_dir_e'(sync_q[SW-1]);
  assign strobe_s = sync_q[SW-2];
  assign bus_s    = sync_q[DATA_W-1:0];

  pp_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (strobe_s),
    .rise (rise)
  );

  pp_rx_path #(.W(DATA_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .wr_rise    (rise && dir_s == XFER_WRITE),
    .bus_sample (bus_s),
    .ib_valid   (ib_valid),
    .ib_ready   (ib_ready),
    .ib_data    (ib_data),
    .ovf_flag   (ovf_flag)
  );

  pp_tx_path #(.W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .rd_rise   (rise && dir_s == XFER_READ),
    .rd_mode   (dir_s == XFER_READ),
    .ob_valid  (ob_valid),
    .ob_data   (ob_data),
    .ob_ready  (ob_ready),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .mcu_ready (mcu_ready),
    .unf_flag  (unf_flag)
  );
endmodule

// File: rtl/pp_bridge_chk.sv
module pp_bridge_chk (
  input logic clk,
  input logic rst,
  input logic mcu_dir,
  input logic pad_oe,
  input logic mcu_ready,
  input logic ib_valid,
  input logic ib_ready,
  input logic ob_valid,
  input logic ob_ready,
  input logic ovf_flag,
  input logic unf_flag
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)              cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R4
  push_single_chk: assert property (@(posedge clk) disable iff (rst)
    ib_valid |=> !ib_valid);

  // R4
  pop_single_chk: assert property (@(posedge clk) disable iff (rst)
    ob_ready |=> !ob_ready);

  // R9
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    ob_ready |-> ob_valid);

  // R5
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(mcu_dir, 3)) |-> !pad_oe);

  // R5
  oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && !$past(mcu_dir, 3)) |-> pad_oe);

  // R7
  ready_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0) |-> (mcu_ready == $past(ob_valid)));

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ib_valid && !ib_ready) |=> ovf_flag);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unf_flag |=> unf_flag);
endmodule

bind pport_bridge pp_bridge_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mcu_dir   (mcu_dir),
  .pad_oe    (pad_oe),
  .mcu_ready (mcu_ready),
  .ib_valid  (ib_valid),
  .ib_ready  (ib_ready),
  .ob_valid  (ob_valid),
  .ob_ready  (ob_ready),
  .ovf_flag  (ovf_flag),
  .unf_flag  (unf_flag)
);

// File: tb/sim_pport_bridge.sv
module sim_pport_bridge;
  localparam int CLK_P = 20;
  localparam int W     = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mcu_strobe = 1'b0;
  logic         mcu_dir = 1'b1;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, ib_data;
  logic         pad_oe, mcu_ready, ib_valid, ob_ready, ovf_flag, unf_flag;
  logic         ib_ready = 1'b1;
  logic         ob_valid = 1'b0;
  logic [W-1:0] ob_data = '0;

  int n_chk = 0, n_fail = 0;
  int push_cnt = 0, pop_cnt = 0;
  int ib_cap = 16;
  logic [W-1:0] ib_q[$];
  logic [W-1:0] ob_q[$];
  bit pop_req = 0, push_req = 0;
  logic [W-1:0] push_dat = '0;

  always #(CLK_P/2) clk = ~clk;

  pport_bridge #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .mcu_strobe(mcu_strobe), .mcu_dir(mcu_dir),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .mcu_ready(mcu_ready),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_data(ib_data),
    .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_data(ob_data),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  // FIFO models: a handshake seen at one falling edge is applied at the next
  always @(negedge clk) begin
    bit pr, pw;
    logic [W-1:0] wd;
    pr = ob_ready;
    pw = ib_valid && ib_ready;
    wd = ib_data;
    if (pop_req) begin
      if (ob_q.size() > 0) void'(ob_q.pop_front());
      pop_cnt++;
    end
    if (push_req) begin
      ib_q.push_back(push_dat);
      push_cnt++;
    end
    pop_req  = pr;
    push_req = pw;
    push_dat = wd;
    ob_valid = ob_q.size() > 0;
    ob_data  = (ob_q.size() > 0) ? ob_q[0] : '0;
    ib_ready = ib_q.size() < ib_cap;
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mcu_write(input logic [W-1:0] b);
    mcu_dir = 1'b1;
    pad_in  = b;
    tick(3);
    mcu_strobe = 1'b1;
    tick(4);
    mcu_strobe = 1'b0;
    tick(4);
  endtask

  task automatic mcu_read(output logic [W-1:0] got);
    mcu_dir = 1'b0;
    tick(4);
    got = pad_out;
    mcu_strobe = 1'b1;
    tick(4);
    mcu_strobe = 1'b0;
    tick(4);
  endtask

  function automatic logic [W-1:0] ob_val(input int i);
    return W'((i * 7 + 3) & 255);
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    int pc, qc;

    // R10: reset state
    tick(3);
    check(pad_oe == 1'b0,    "R10 oe",    32'(pad_oe), 0);
    check(mcu_ready == 1'b0, "R10 ready", 32'(mcu_ready), 0);
    check(!ovf_flag && !unf_flag, "R10 flags", {ovf_flag, unf_flag}, 0);
    check(pad_out == '0,     "R10 pad_out", 32'(pad_out), 0);
    rst = 1'b0;
    tick(4);

    // R5: output enable turnaround timing
    mcu_dir = 1'b0;
    tick(2);
    check(pad_oe == 1'b0, "R5 oe early", 32'(pad_oe), 0);
    tick(1);
    check(pad_oe == 1'b1, "R5 oe on",    32'(pad_oe), 1);
    mcu_dir = 1'b1;
    tick(2);
    check(pad_oe == 1'b1, "R5 oe hold",  32'(pad_oe), 1);
    tick(1);
    check(pad_oe == 1'b0, "R5 oe off",   32'(pad_oe), 0);

    // R1: pulse position, long high phase, falling edge ignored (R4)
    pad_in = 8'hA5;
    tick(3);
    mcu_strobe = 1'b1;
    tick(1);
    check(ib_valid == 1'b0, "R1 pulse early", 32'(ib_valid), 0);
    tick(1);
    check(ib_valid == 1'b1 && ib_data == 8'hA5, "R1 pulse due", {ib_valid, ib_data}, {1'b1, 8'hA5});
    tick(1);
    check(ib_valid == 1'b0, "R1 pulse width", 32'(ib_valid), 0);
    tick(8);
    check(push_cnt == 1, "R4 one push for long strobe", push_cnt, 1);
    mcu_strobe = 1'b0;
    tick(6);
    check(push_cnt == 1, "R1 falling edge no transfer", push_cnt, 1);
    check(ib_q.size() == 1 && ib_q[0] == 8'hA5, "R2 captured", 32'(ib_q[0]), 32'hA5);
    ib_q.delete();
    tick(2);

    // R2: sweep every byte value through a write
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] e;
      e = W'(v) ^ 8'h5A;
      pc = push_cnt;
      mcu_write(e);
      check(ib_q.size() == 1 && ib_q[0] == e && push_cnt == pc + 1,
            "R2 write byte", {ib_q.size() == 1, ib_q[0]}, {1'b1, e});
      ib_q.delete();
    end
    check(pop_cnt == 0, "R2 no pop on write", pop_cnt, 0);
    tick(2);

    // R8: overflow with capacity 3
    ib_cap = 3;
    tick(2);
    for (int k = 0; k < 3; k++) mcu_write(W'(8'h10 + k));
    check(ovf_flag == 1'b0 && ib_q.size() == 3, "R8 fill no ovf", {ovf_flag, 8'(ib_q.size())}, {1'b0, 8'd3});
    mcu_write(8'hEE);
    check(ovf_flag == 1'b1, "R8 ovf set", 32'(ovf_flag), 1);
    check(ib_q.size() == 3 && ib_q[2] == 8'h12, "R8 byte dropped", 32'(ib_q.size()), 3);
    ib_q.delete();
    ib_cap = 16;
    tick(4);
    check(ovf_flag == 1'b1, "R8 ovf sticky", 32'(ovf_flag), 1);

    // R3/R6/R7: read sweep over 256 queued bytes
    for (int i = 0; i < 256; i++) ob_q.push_back(ob_val(i));
    mcu_dir = 1'b0;
    tick(4);
    check(mcu_ready == 1'b1, "R7 ready with data", 32'(mcu_ready), 1);
    for (int i = 0; i < 256; i++) begin
      pc = pop_cnt;
      qc = push_cnt;
      mcu_read(got);
      check(got == ob_val(i), "R6 bus shows head", 32'(got), 32'(ob_val(i)));
      check(pop_cnt == pc + 1 && push_cnt == qc, "R3 one pop no push", pop_cnt, pc + 1);
    end
    check(pad_oe == 1'b1, "R5 oe while reading", 32'(pad_oe), 1);
    check(mcu_ready == 1'b0, "R7 ready when empty", 32'(mcu_ready), 0);
    check(pad_out == ob_val(255), "R6 hold when empty", 32'(pad_out), 32'(ob_val(255)));
    check(unf_flag == 1'b0, "R9 no unf yet", 32'(unf_flag), 0);

    // R9: underflow
    pc = pop_cnt;
    mcu_read(got);
    check(unf_flag == 1'b1, "R9 unf set", 32'(unf_flag), 1);
    check(pop_cnt == pc, "R9 no pop when empty", pop_cnt, pc);
    tick(5);
    check(unf_flag == 1'b1, "R9 unf sticky", 32'(unf_flag), 1);

    // R10: reset clears flags and enable
    rst = 1'b1;
    tick(2);
    check(!ovf_flag && !unf_flag && !pad_oe && pad_out == '0, "R10 rerun reset",
          {ovf_flag, unf_flag, pad_oe}, 0);
    rst = 1'b0;
    tick(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule